// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static Memory Model with Control Decode

This block is a synthesizable stand-in for an asynchronous static memory of byte-wide words. It is meant to be placed as the target device in a memory controller's testbench or in an emulation build. The bidirectional data bus is split into an input byte, an output byte and a drive-enable, so the model needs no tristate logic. A fast sampling clock observes the asynchronous control pins: an active-low select, an active-high enable, an active-low write strobe and an active-low output gate.

The model sorts every sampled cycle into one of four modes: deselected, disabled, read or write. A write window is open while select is low, enable is high and the write strobe is low. Any of these three controls may be the one that opens or closes the window. The byte is stored when the window closes, using the address and data seen in the window's final cycle. A read produces a don't-care pattern until a programmable number of sampling cycles has passed since the latest address change or selection. A sticky flag records an address change made while the write window stays open.

Full device depth is reached with `ADDR_W = 15` (32,768 bytes). The default parameter set is a smaller array with the same behaviour.

Top module: `sram_ctl_model`

## Requirements
- R1: The array holds 2**ADDR_W bytes. A byte written to any address is returned by a later read of that address.
- R2: `dout_oe_o` is 1 only when `cs_n_i`=0, `ce_i`=1, `we_n_i`=1 and `oe_n_i`=0. When `oe_n_i`=1 it is 0, whatever the other controls are, and the read timer is unaffected.
- R3: The write window is `cs_n_i`=0, `ce_i`=1, `we_n_i`=0. During it `dout_oe_o` is 0 and the level of `oe_n_i` has no effect.
- R4: When `cs_n_i`=1 or `ce_i`=0, `dout_oe_o` is 0 and the write strobe and data inputs leave the array unchanged.
- R5: A write is committed at the first clock edge where the window is found closed. It stores the address and data sampled in the last cycle the window was open. Raising `we_n_i`, raising `cs_n_i` or lowering `ce_i` each closes the window.
- R6: In read mode, `dout_o` shows the pattern `DC_PAT` from the cycle an access starts until ACCESS_LAT clock edges have passed. An access starts on entry to read mode or on any address change while in read mode. After that, `dout_o` shows the stored byte.
- R7: If the address differs from the address of the previous cycle while the write window is open in both cycles, `err_o` rises at the next edge. It stays 1 until reset.
- R8: Two writes separated by one cycle in which only the write strobe returns high both commit, to their own addresses, and raise no error.
- R9: During and just after reset, `dout_oe_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| cs_n_i | input | 1 | Select, active low |
| ce_i | input | 1 | Enable, active high |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output gate, active low |
| din_i | input | DATA_W | Write data |
| dout_o | output | DATA_W | Read data or `DC_PAT` |
| dout_oe_o | output | 1 | Data bus drive enable |
| err_o | output | 1 | Sticky address-change-during-write flag |

## Verification
The assertions assume the control and address pins are already synchronous to the sampling clock, with each level held for at least one full cycle. The stimulus satisfies this because it changes every input only at falling edges. The checks on the error flag and on fresh accesses compare the current address against the previous cycle's. They assume at least one edge has passed since reset, and a local ready register in the checker provides that.

// File: rtl/sram_mdl_pkg.sv
package sram_mdl_pkg;
  typedef enum logic [1:0] {
    MD_DESEL    = 2'd0,
    MD_DISABLED = 2'd1,
    MD_READ     = 2'd2,
    MD_WRITE    = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_mdl_decode.sv
module sram_mdl_decode
  import sram_mdl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              cs_n_i,
  input  logic              ce_i,
  input  logic              we_n_i,
  output mode_e             mode_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              err_o
);
  logic              open_q, open_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q, err_d;
  logic              wr_open;

  // mode priority: select, then enable, then write strobe
  always_comb begin
    if (cs_n_i)      mode_o = MD_DESEL;
    else if (!ce_i)  mode_o = MD_DISABLED;
    else if (!we_n_i) mode_o = MD_WRITE;
    else             mode_o = MD_READ;
  end

  assign wr_open = (mode_o == MD_WRITE);

  always_comb begin
    open_d = wr_open;
    addr_d = addr_q;
    data_d = data_q;
    if (wr_open) begin
      addr_d = addr_i;
      data_d = din_i;
    end
    err_d = err_q | (wr_open & open_q & (addr_i != addr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      addr_q <= addr_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign commit_o      = open_q & ~wr_open;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;
  assign err_o         = err_q;
endmodule

// File: rtl/sram_mdl_timer.sv
module sram_mdl_timer #(
  parameter int ADDR_W     = 8,
  parameter int ACCESS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_i,
  output logic              valid_o
);
  localparam int CNT_W = (ACCESS_LAT < 2) ? 1 : $clog2(ACCESS_LAT + 1);

  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              start;

  assign start = rd_sel_i & (~rd_q | (addr_i != addr_q));

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = CNT_W'(ACCESS_LAT);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rd_q   <= rd_sel_i;
      addr_q <= addr_i;
      cnt_q  <= cnt_d;
    end
  end

  assign valid_o = rd_sel_i & ~start & (cnt_q == '0);
endmodule

// File: rtl/sram_mdl_store.sv
module sram_mdl_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/sram_ctl_model.sv
module sram_ctl_model
  import sram_mdl_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter int              ACCESS_LAT = 3,
  parameter logic [DATA_W-1:0] DC_PAT   = DATA_W'('h5A)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              ce_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic              err_o
);
  mode_e             mode;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic              rd_sel;
  logic              rd_valid;
  logic [DATA_W-1:0] rdata;

  sram_mdl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) decode_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
    .cs_n_i(cs_n_i), .ce_i(ce_i), .we_n_i(we_n_i),
    .mode_o(mode), .commit_o(commit), .commit_addr_o(commit_addr),
    .commit_data_o(commit_data), .err_o(err_o)
  );

  assign rd_sel = (mode == MD_READ);

  sram_mdl_timer #(.ADDR_W(ADDR_W), .ACCESS_LAT(ACCESS_LAT)) timer_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_sel_i(rd_sel),
    .valid_o(rd_valid)
  );

  sram_mdl_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .we_i(commit), .waddr_i(commit_addr), .wdata_i(commit_data),
    .raddr_i(addr_i), .rdata_o(rdata)
  );

  assign dout_oe_o = rd_sel & ~oe_n_i;
  assign dout_o    = rd_valid ? rdata : DC_PAT;
endmodule

// File: rtl/sram_ctl_model_chk.sv
module sram_ctl_model_chk #(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter int              ACCESS_LAT = 3,
  parameter logic [DATA_W-1:0] DC_PAT   = DATA_W'('h5A)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cs_n_i,
  input logic              ce_i,
  input logic              we_n_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_oe_o,
  input logic              err_o
);
  logic live_q;
  logic wopen, rdsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign wopen = !cs_n_i && ce_i && !we_n_i;
  assign rdsel = !cs_n_i && ce_i && we_n_i;

  p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !dout_oe_o);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wopen |-> !dout_oe_o);

  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || !ce_i) |-> !dout_oe_o);

  p_fresh_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ACCESS_LAT > 0 && live_q && rdsel && addr_i != $past(addr_i)) |-> dout_o == DC_PAT);

  p_err_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wopen && $past(wopen) && addr_i != $past(addr_i)) |=> err_o);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind sram_ctl_model sram_ctl_model_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_LAT(ACCESS_LAT), .DC_PAT(DC_PAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i), .ce_i(ce_i),
  .we_n_i(we_n_i), .oe_n_i(oe_n_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
  .err_o(err_o)
);

// File: tb/sram_ctl_model_tb_top.sv
module sram_ctl_model_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam logic [DW-1:0] PAT = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cs_n, ce, we_n, oe_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe, err;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl_model #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_LAT(LAT), .DC_PAT(PAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_n_i(cs_n), .ce_i(ce),
    .we_n_i(we_n), .oe_n_i(oe_n), .din_i(din), .dout_o(dout),
    .dout_oe_o(dout_oe), .err_o(err)
  );

  function automatic logic [DW-1:0] fill(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0;
  endtask

  // closer: 0 raises write strobe, 1 raises select, 2 drops enable
  task automatic wr(input int a, input logic [DW-1:0] d, input int closer);
    @(negedge clk);
    addr = AW'(a); din = d; cs_n = 1'b0; ce = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    case (closer)
      0: we_n = 1'b1;
      1: cs_n = 1'b1;
      default: ce = 1'b0;
    endcase
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input bit detail, input string req);
    @(negedge clk);
    addr = AW'(a); cs_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    for (int n = 0; n < LAT; n++) begin
      @(negedge clk);
      if (detail) chk(dout == PAT, "R6 pattern before latency", int'(dout), int'(PAT));
    end
    @(negedge clk);
    chk(dout_oe == 1'b1, "R2 drive during read", int'(dout_oe), 1);
    chk(dout == exp, req, int'(dout), int'(exp));
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; din = '0; idle();
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R9 reset drive", int'(dout_oe), 0);
    chk(err == 1'b0, "R9 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R9 err after reset", int'(err), 0);

    // R1/R5: fill every address, rotating the closing control
    for (int a = 0; a < (1 << AW); a++) wr(a, fill(a), a % 3);
    @(negedge clk);
    for (int a = 0; a < (1 << AW); a++) begin
      rd(a, fill(a), 1'b0, "R1 readback");
      @(negedge clk); idle();
    end

    // R6: latency and address change while selected
    rd(3, fill(3), 1'b1, "R6 data after latency");
    @(negedge clk); addr = 8'd4;
    for (int n = 0; n < LAT; n++) begin
      @(negedge clk);
      chk(dout == PAT, "R6 pattern after address change", int'(dout), int'(PAT));
    end
    @(negedge clk);
    chk(dout == fill(4), "R6 new data", int'(dout), int'(fill(4)));

    // R2: output gate blocks drive, timer unaffected
    oe_n = 1'b1;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R2 gate high", int'(dout_oe), 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk(dout_oe == 1'b1, "R2 gate low", int'(dout_oe), 1);
    chk(dout == fill(4), "R2 data kept", int'(dout), int'(fill(4)));
    idle();

    // R3: write window with gate low keeps bus quiet
    @(negedge clk);
    addr = 8'd50; din = 8'hC3; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R3 quiet in write", int'(dout_oe), 0);
    we_n = 1'b1; @(negedge clk); idle();
    rd(50, 8'hC3, 1'b0, "R3 write stored");

    // R4: strobes while deselected or disabled are ignored
    @(negedge clk);
    addr = 8'd10; din = 8'h00; cs_n = 1'b1; ce = 1'b1; we_n = 1'b0;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R4 deselected quiet", int'(dout_oe), 0);
    we_n = 1'b1; @(negedge clk);
    cs_n = 1'b0; ce = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R4 disabled quiet", int'(dout_oe), 0);
    we_n = 1'b1; @(negedge clk); idle();
    rd(10, fill(10), 1'b0, "R4 array unchanged");

    // R5: last cycle of the window is stored
    @(negedge clk); idle();
    @(negedge clk);
    addr = 8'd20; din = 8'h11; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk); din = 8'h22;
    @(negedge clk); cs_n = 1'b1; din = 8'h33;
    @(negedge clk); idle();
    rd(20, 8'h22, 1'b0, "R5 last-cycle capture");

    // R8: back-to-back writes split by one strobe-high cycle
    @(negedge clk); idle();
    @(negedge clk);
    addr = 8'd30; din = 8'h33; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); addr = 8'd31; din = 8'h44; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); idle();
    chk(err == 1'b0, "R8 no error", int'(err), 0);
    rd(30, 8'h33, 1'b0, "R8 first write");
    @(negedge clk); idle();
    rd(31, 8'h44, 1'b0, "R8 second write");

    // R7: address change inside open window
    @(negedge clk); idle();
    @(negedge clk);
    addr = 8'd40; din = 8'h01; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R7 no error yet", int'(err), 0);
    addr = 8'd41;
    @(negedge clk);
    chk(err == 1'b1, "R7 error raised", int'(err), 1);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    idle();
    @(negedge clk);
    chk(err == 1'b1, "R7 error sticky", int'(err), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R9 reset clears error", int'(err), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule